// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO Controller

This block divides one data store into `NQ` (one to four) first-in first-out queues that share a single write port and a single read port, both clocked by one common clock. The store is cut into equal partitions of `QDEPTH` words, one per queue. Each queue keeps its own write pointer, read pointer and fill count, and each pointer wraps inside its own partition. Each port carries a queue number and a load strobe that makes that queue the active one for the port. Data moves on every cycle the enables allow, including the cycle in which the active queue changes.

The read side works in first-word-fall-through fashion through a two-entry output pipeline. A single valid flag says whether the word on `rd_data` is real. Selecting a queue number at or above `NQ` on the read port parks it on a null queue, so a packet read can stop without pulling more words into the pipeline. The write port shows the full and almost-full status of its active queue. The read port shows the almost-empty status of its active queue. A flush input empties one queue when that queue is active on both ports. The almost-full and almost-empty offsets are both `LO_OFF` or both `HI_OFF`, chosen by a pin that is sampled while reset is held.

Top module: `mqfifo_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, every queue is empty, the active write queue is 0 and the read port is on the null queue. Until the first read select, `rd_valid`, `wr_full` and `wr_afull` read 0, `rd_aempty` reads 1, and words written to queue 0 never reach `rd_data`.
- R2: `wr_qld` high with `wr_qid` < `NQ` makes `wr_qid` the active write queue from the next cycle on. A write in the select cycle itself still goes to the previously active queue. `wr_qld` with `wr_qid` >= `NQ` leaves the active write queue unchanged.
- R3: After a select on either port, `wr_full` / `wr_afull` (write port) or `rd_aempty` (read port) show the newly chosen queue's status from the second rising edge after the select cycle. At the first edge they still show the old queue.
- R4: When `rd_valid` is 0 and the active read queue holds data, the oldest word appears on `rd_data` with `rd_valid` = 1 without `rd_en`; this happens two edges after a read select. `rd_en` high while `rd_valid` is 1 consumes that word. A word that is not consumed stays stable. Each queue returns its words in write order.
- R5: With `rd_en` held high and data available, a valid word is presented every cycle, also across a read-queue change. Words already fetched from the old queue come out first, then the new queue's words follow in order.
- R6: Any `rd_qid` >= `NQ` selects the null queue. No further word is fetched from any queue. At most two words already in the pipeline are still delivered. After that `rd_valid` stays 0 and `rd_aempty` is 1. Words left in the queue are returned in order when it is selected again.
- R7: `wr_full` is 1 when the active write queue holds `QDEPTH` words. A write to a full queue is ignored, so exactly `QDEPTH` words are read back.
- R8: `rd_en` while `rd_valid` is 0 has no effect. Words written later come out normally.
- R9: The offset is `HI_OFF` (default 128) if `thr_sel` is 1 during reset, else `LO_OFF` (default 8). `wr_afull` = count + offset >= `QDEPTH`. `rd_aempty` = count <= offset. Count is the number of words stored in the queue, not counting the up to two words already moved into the read pipeline.
- R10: `qflush` empties a queue only when the same queue is active on both ports. It then also drops the read pipeline (`rd_valid` = 0, `rd_aempty` = 1 on the next edge) and leaves other queues intact. Otherwise `qflush` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low master reset |
| thr_sel | input | 1 | Offset choice, sampled during reset (1 = high offset) |
| wr_data | input | DW | Write data |
| wr_en | input | 1 | Write enable for the active write queue |
| wr_qid | input | QIDW | Queue number presented for a write select |
| wr_qld | input | 1 | Load strobe taking `wr_qid` as the active write queue |
| rd_en | input | 1 | Consume the word on `rd_data` |
| rd_qid | input | QIDW | Queue number for a read select (>= NQ is the null queue) |
| rd_qld | input | 1 | Load strobe taking `rd_qid` as the active read queue |
| qflush | input | 1 | Flush the queue active on both ports |
| rd_data | output | DW | First-word-fall-through read data |
| rd_valid | output | 1 | `rd_data` holds a valid word |
| wr_full | output | 1 | Active write queue is full |
| wr_afull | output | 1 | Active write queue is almost full |
| rd_aempty | output | 1 | Active read queue is almost empty |

## Verification
The two functions that can fall in one cycle are a change of the active queue and a data transfer on the same port. On the write port this is a write issued in the very cycle of the write select. On the read port it is a read select issued while `rd_en` is held high in a continuous stream. The bench provokes the write case by raising the strobe and the enable together, and judges it by which queue the word is later read from. It provokes the read case by toggling the read strobe in the middle of a ten-cycle stream, and judges it by requiring a valid word in every cycle, an in-order prefix of the old queue and then the new queue from its first word. Partial-reset timing, flag lag after a select and the null-queue drain are checked in their own scenarios.

// File: rtl/mqfifo_pkg.sv
package mqfifo_pkg;

  localparam int MQ_MAX_Q = 4;

  // Physical word index of a queue slot: partitions are laid out back to back.
  function automatic int slot_index(input int qnum, input int ptr, input int depth);
    return qnum * depth + ptr;
  endfunction

  function automatic logic q_is_full(input int unsigned cnt, input int unsigned depth);
    return cnt == depth;
  endfunction

  function automatic logic q_near_full(input int unsigned cnt, input int unsigned depth,
                                       input int unsigned off);
    return (cnt + off) >= depth;
  endfunction

  function automatic logic q_near_empty(input int unsigned cnt, input int unsigned off);
    return cnt <= off;
  endfunction

endpackage

// File: rtl/mqfifo_store.sv
module mqfifo_store #(
  parameter int DW    = 16,
  parameter int WORDS = 1024,
  localparam int MW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [MW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [MW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mqfifo_qctr.sv
module mqfifo_qctr #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          clr,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt_nxt,
  output logic          push_ev,
  output logic          pop_ev
);

  logic [CW-1:0] cnt;
  logic          full, empty;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ev = push_req & ~full & ~clr;
  assign pop_ev  = pop_req & ~empty & ~clr;
  assign cnt_nxt = clr ? '0 : (cnt + CW'(push_ev) - CW'(pop_ev));

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ev) wptr <= bump(wptr);
      if (pop_ev)  rptr <= bump(rptr);
      cnt <= cnt_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (full && !pop_req && !clr) |=> $stable(cnt)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (empty && !push_req && !clr) |=> $stable(cnt)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R7

endmodule

// File: rtl/mqfifo_outpipe.sv
module mqfifo_outpipe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rd_en,
  input  logic          fetch_ok,
  input  logic [DW-1:0] fetch_data,
  output logic          fetch_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  // Stage behind the output register; the output register is the second stage.
  logic          st_v;
  logic [DW-1:0] st_d;
  logic          take;

  assign take      = rd_en | ~rd_valid;
  assign fetch_req = take | ~st_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      st_v     <= 1'b0;
      st_d     <= '0;
    end else if (flush) begin
      rd_valid <= 1'b0;
      st_v     <= 1'b0;
    end else if (take) begin
      if (st_v) begin
        rd_valid <= 1'b1;
        rd_data  <= st_d;
        st_v     <= fetch_ok;
        if (fetch_ok) st_d <= fetch_data;
      end else begin
        rd_valid <= fetch_ok;
        if (fetch_ok) rd_data <= fetch_data;
      end
    end else if (fetch_ok) begin
      st_v <= 1'b1;
      st_d <= fetch_data;
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_en && !flush) |=> (rd_valid && $stable(rd_data))); // R4
  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !rd_valid); // R10
  AST_FETCH_ASKED: assert property (@(posedge clk) disable iff (!rst_n) fetch_ok |-> fetch_req); // R5

endmodule

// File: rtl/mqfifo_ctrl.sv
module mqfifo_ctrl
  import mqfifo_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NQ      = 4,
  parameter int QDEPTH  = 256,
  parameter int LO_OFF  = 8,
  parameter int HI_OFF  = 128,
  localparam int QIDW   = $clog2(NQ + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            thr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            wr_en,
  input  logic [QIDW-1:0] wr_qid,
  input  logic            wr_qld,
  input  logic            rd_en,
  input  logic [QIDW-1:0] rd_qid,
  input  logic            rd_qld,
  input  logic            qflush,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            wr_full,
  output logic            wr_afull,
  output logic            rd_aempty
);

  localparam int AW    = $clog2(QDEPTH);
  localparam int CW    = AW + 1;
  localparam int WORDS = NQ * QDEPTH;
  localparam int MW    = $clog2(WORDS);

  // Active queue registers and offset choice
  logic [QIDW-1:0] wq, rq;
  logic            hi_off;
  logic            rd_null, flush_take;
  int unsigned     off_val;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_off <= thr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq <= '0;
      rq <= QIDW'(NQ);
    end else begin
      if (wr_qld && (wr_qid < QIDW'(NQ))) wq <= wr_qid;
      if (rd_qld) rq <= rd_qid;
    end
  end

  assign off_val    = hi_off ? HI_OFF : LO_OFF;
  assign rd_null    = (rq >= QIDW'(NQ));
  assign flush_take = qflush & ~rd_null & (wq == rq);

  // Per-queue state
  logic [AW-1:0] wptr_a    [NQ];
  logic [AW-1:0] rptr_a    [NQ];
  logic [CW-1:0] cnt_nxt_a [NQ];
  logic [NQ-1:0] push_req_v, pop_req_v, clr_v, push_ev_v, pop_ev_v;
  logic          fetch_req, fetch_ok;

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    assign push_req_v[g] = wr_en & (wq == QIDW'(g));
    assign pop_req_v[g]  = fetch_req & (rq == QIDW'(g));
    assign clr_v[g]      = flush_take & (wq == QIDW'(g));

    mqfifo_qctr #(.DEPTH(QDEPTH)) u_qctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push_req_v[g]),
      .pop_req  (pop_req_v[g]),
      .clr      (clr_v[g]),
      .wptr     (wptr_a[g]),
      .rptr     (rptr_a[g]),
      .cnt_nxt  (cnt_nxt_a[g]),
      .push_ev  (push_ev_v[g]),
      .pop_ev   (pop_ev_v[g])
    );
  end

  // Steer the active queues' pointers and next counts
  int            w_idx, r_idx;
  logic [AW-1:0] w_ptr, r_ptr;
  logic [CW-1:0] wcnt_nxt, rcnt_nxt;

  always_comb begin
    w_idx    = 0;
    r_idx    = 0;
    w_ptr    = wptr_a[0];
    r_ptr    = rptr_a[0];
    wcnt_nxt = cnt_nxt_a[0];
    rcnt_nxt = cnt_nxt_a[0];
    for (int q = 0; q < NQ; q++) begin
      if (wq == QIDW'(q)) begin
        w_idx    = q;
        w_ptr    = wptr_a[q];
        wcnt_nxt = cnt_nxt_a[q];
      end
      if (rq == QIDW'(q)) begin
        r_idx    = q;
        r_ptr    = rptr_a[q];
        rcnt_nxt = cnt_nxt_a[q];
      end
    end
  end

  // Shared storage
  logic [MW-1:0] waddr, raddr;
  logic [DW-1:0] fetch_data;

  assign waddr    = MW'(slot_index(w_idx, 32'(w_ptr), QDEPTH));
  assign raddr    = MW'(slot_index(r_idx, 32'(r_ptr), QDEPTH));
  assign fetch_ok = |pop_ev_v;

  mqfifo_store #(.DW(DW), .WORDS(WORDS)) u_store (
    .clk   (clk),
    .we    (|push_ev_v),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (fetch_data)
  );

  mqfifo_outpipe #(.DW(DW)) u_outpipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_take),
    .rd_en      (rd_en),
    .fetch_ok   (fetch_ok),
    .fetch_data (fetch_data),
    .fetch_req  (fetch_req),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  // Active-queue flags: status after this edge of the queue active before it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_full   <= 1'b0;
      wr_afull  <= 1'b0;
      rd_aempty <= 1'b1;
    end else begin
      wr_full   <= q_is_full(32'(wcnt_nxt), QDEPTH);
      wr_afull  <= q_near_full(32'(wcnt_nxt), QDEPTH, off_val);
      rd_aempty <= rd_null ? 1'b1 : q_near_empty(32'(rcnt_nxt), off_val);
    end
  end

  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pop_ev_v)); // R5
  AST_NULL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n) rd_null |-> (pop_ev_v == '0)); // R6
  AST_FULL_HAS_AF: assert property (@(posedge clk) disable iff (!rst_n) wr_full |-> wr_afull); // R9
  AST_FLUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) flush_take |=> (rd_aempty && !wr_full && !rd_valid)); // R10
  AST_WSEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (wr_qld && (wr_qid >= QIDW'(NQ))) |=> $stable(wq)); // R2

endmodule

// File: tb/mqfifo_ctrl_tb.sv
module mqfifo_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        thr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_qid = '0;
  logic        wr_qld = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_qid = '0;
  logic        rd_qld = 1'b0;
  logic        qflush = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid, wr_full, wr_afull, rd_aempty;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mqfifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel),
    .wr_data(wr_data), .wr_en(wr_en), .wr_qid(wr_qid), .wr_qld(wr_qld),
    .rd_en(rd_en), .rd_qid(rd_qid), .rd_qld(rd_qld), .qflush(qflush),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_full(wr_full), .wr_afull(wr_afull), .rd_aempty(rd_aempty)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit thr);
    @(negedge clk);
    rst_n = 1'b0; thr_sel = thr;
    wr_en = 0; wr_qld = 0; rd_en = 0; rd_qld = 0; qflush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wsel(input int q);
    wr_qld = 1'b1; wr_qid = 3'(q);
    @(negedge clk);
    wr_qld = 1'b0;
  endtask

  task automatic rsel(input int q);
    rd_qld = 1'b1; rd_qid = 3'(q);
    @(negedge clk);
    rd_qld = 1'b0;
  endtask

  task automatic wr_words(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = 16'(base + i);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic pop_one(input int exp, input string req);
    int t = 0;
    while (!rd_valid && t < 20) begin
      @(negedge clk);
      t++;
    end
    chk(rd_valid && (rd_data == 16'(exp)), req, "read word", rd_valid ? int'(rd_data) : -1, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_dry(input string req);
    idle(3);
    chk(!rd_valid, req, "no further word", int'(rd_valid), 0);
  endtask

  // R1: reset state, read port parked on null queue
  task automatic t_reset;
    do_reset(1'b0);
    chk(!rd_valid, "R1", "rd_valid", int'(rd_valid), 0);
    chk(!wr_full, "R1", "wr_full", int'(wr_full), 0);
    chk(!wr_afull, "R1", "wr_afull", int'(wr_afull), 0);
    chk(rd_aempty, "R1", "rd_aempty", int'(rd_aempty), 1);
    wr_words(3, 16'h0100);
    idle(3);
    chk(!rd_valid, "R1", "no read before select", int'(rd_valid), 0);
  endtask

  // R2, R4, R8: write select timing, ignored select, FWFT order, empty reads
  task automatic t_select;
    do_reset(1'b0);
    wr_words(3, 16'h0000);
    wr_qld = 1'b1; wr_qid = 3'd1; wr_en = 1'b1; wr_data = 16'h0003;
    @(negedge clk);
    wr_qld = 1'b0;
    wr_words(3, 16'h1000);
    wr_qld = 1'b1; wr_qid = 3'd5; wr_en = 1'b1; wr_data = 16'h1003;
    @(negedge clk);
    wr_qld = 1'b0;
    wr_words(1, 16'h1004);
    rsel(0);
    chk(!rd_valid, "R4", "valid one edge after select", int'(rd_valid), 0);
    @(negedge clk);
    chk(rd_valid && rd_data == 16'h0000, "R4", "fall-through word two edges after select",
        int'(rd_data), 16'h0000);
    for (int i = 0; i < 4; i++) pop_one(i, "R2");
    expect_dry("R2");
    rsel(1);
    for (int i = 0; i < 5; i++) pop_one(16'h1000 + i, "R2");
    expect_dry("R2");
    rd_en = 1'b1;
    idle(3);
    rd_en = 1'b0;
    chk(!rd_valid, "R8", "read of empty queue", int'(rd_valid), 0);
    wr_words(2, 16'h1010);
    pop_one(16'h1010, "R8");
    pop_one(16'h1011, "R8");
  endtask

  // R3, R7: flag lag after select on both ports, overflow ignored
  task automatic t_full;
    do_reset(1'b0);
    wsel(2);
    wr_words(256, 16'h2000);
    chk(wr_full, "R7", "wr_full at depth", int'(wr_full), 1);
    wr_words(1, 16'h2FFF);
    wr_qld = 1'b1; wr_qid = 3'd3;
    @(negedge clk);
    wr_qld = 1'b0;
    chk(wr_full, "R3", "wr_full one edge after select", int'(wr_full), 1);
    @(negedge clk);
    chk(!wr_full, "R3", "wr_full two edges after select", int'(wr_full), 0);
    rd_qld = 1'b1; rd_qid = 3'd2;
    @(negedge clk);
    rd_qld = 1'b0;
    chk(rd_aempty, "R3", "rd_aempty one edge after select", int'(rd_aempty), 1);
    @(negedge clk);
    chk(!rd_aempty, "R3", "rd_aempty two edges after select", int'(rd_aempty), 0);
    for (int i = 0; i < 256; i++) pop_one(16'h2000 + i, "R7");
    expect_dry("R7");
  endtask

  // R5: continuous reads across a read-queue change
  task automatic t_stream;
    int  k0 = 0;
    int  k1 = 0;
    bit  gap = 1'b0;
    bit  bad = 1'b0;
    int  t = 0;
    do_reset(1'b0);
    wr_words(10, 16'h0000);
    wsel(1);
    wr_words(8, 16'h1000);
    rsel(0);
    while (!rd_valid && t < 10) begin
      @(negedge clk);
      t++;
    end
    rd_en = 1'b1;
    for (int c = 0; c < 10; c++) begin
      rd_qld = (c == 3); rd_qid = 3'd1;
      if (!rd_valid) gap = 1'b1;
      else if (k1 == 0 && rd_data == 16'(k0)) k0++;
      else if (rd_data == 16'(16'h1000 + k1)) k1++;
      else bad = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0; rd_qld = 1'b0;
    chk(!gap, "R5", "valid word every cycle", int'(gap), 0);
    chk(!bad, "R5", "old prefix then new queue in order", int'(bad), 0);
    chk(k0 >= 3 && k1 >= 1, "R5", "words from both queues", k0 * 16 + k1, 0);
  endtask

  // R6: null queue stops fetching; remaining words preserved
  task automatic t_null;
    int d = 0;
    do_reset(1'b0);
    wr_words(5, 16'h0000);
    rsel(0);
    pop_one(0, "R6");
    rsel(7);
    for (int i = 0; i < 4; i++) begin
      if (rd_valid) begin
        chk(rd_data == 16'(1 + d), "R6", "drained word", int'(rd_data), 1 + d);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d++;
      end
    end
    chk(d >= 1 && d <= 2, "R6", "words drained after null select", d, 2);
    idle(4);
    chk(!rd_valid, "R6", "rd_valid on null queue", int'(rd_valid), 0);
    chk(rd_aempty, "R6", "rd_aempty on null queue", int'(rd_aempty), 1);
    rsel(0);
    for (int i = 1 + d; i < 5; i++) pop_one(i, "R6");
    expect_dry("R6");
  endtask

  // R9: both offsets and both thresholds
  task automatic t_offsets;
    do_reset(1'b0);
    wr_words(247, 16'h0000);
    chk(!wr_afull, "R9", "afull at 247 (low offset)", int'(wr_afull), 0);
    wr_words(1, 16'h00F7);
    chk(wr_afull && !wr_full, "R9", "afull at 248 (low offset)", int'(wr_afull), 1);
    wsel(1);
    rsel(1);
    wr_words(10, 16'h1000);
    idle(3);
    chk(rd_aempty, "R9", "aempty with 8 stored", int'(rd_aempty), 1);
    wr_words(1, 16'h100A);
    idle(2);
    chk(!rd_aempty, "R9", "aempty with 9 stored", int'(rd_aempty), 0);
    do_reset(1'b1);
    wr_words(127, 16'h0000);
    chk(!wr_afull, "R9", "afull at 127 (high offset)", int'(wr_afull), 0);
    wr_words(1, 16'h007F);
    chk(wr_afull, "R9", "afull at 128 (high offset)", int'(wr_afull), 1);
  endtask

  // R10: partial reset of one queue
  task automatic t_flush;
    do_reset(1'b0);
    wr_words(4, 16'h0000);
    wsel(2);
    wr_words(3, 16'h2000);
    wsel(1);
    wr_words(3, 16'h1000);
    wsel(0);
    rsel(1);
    idle(2);
    qflush = 1'b1;
    @(negedge clk);
    qflush = 1'b0;
    chk(rd_valid && rd_data == 16'h1000, "R10", "flush ignored when ports differ", int'(rd_data), 16'h1000);
    for (int i = 0; i < 3; i++) pop_one(16'h1000 + i, "R10");
    rsel(0);
    idle(2);
    chk(rd_valid && rd_data == 16'h0000, "R10", "queue 0 head before flush", int'(rd_data), 0);
    qflush = 1'b1;
    @(negedge clk);
    qflush = 1'b0;
    chk(!rd_valid, "R10", "pipeline dropped by flush", int'(rd_valid), 0);
    chk(rd_aempty, "R10", "rd_aempty after flush", int'(rd_aempty), 1);
    expect_dry("R10");
    wr_words(2, 16'h0A00);
    pop_one(16'h0A00, "R10");
    pop_one(16'h0A01, "R10");
    expect_dry("R10");
    rsel(2);
    for (int i = 0; i < 3; i++) pop_one(16'h2000 + i, "R10");
  endtask

  initial begin
    t_reset();
    t_select();
    t_full();
    t_stream();
    t_null();
    t_offsets();
    t_flush();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule